// File: doc/BRIEF.md
# T1 Frame Timing and Channel Gate Generator

This block derives all T1 frame timing from a 1.544 MHz bit clock, one bit per clock cycle. Each 193-bit frame starts with a single framing bit, after which come 24 channels of eight bits, the most significant bit of each channel first. From its internal counters the block reports whether the current bit is the framing bit, which channel and bit are being carried, a channel clock that marks each channel's last bit, and a gate that a per-channel mask can raise for selected channels only. Fractional-rate and drop-and-insert logic uses these signals to pick out its time slots.

The block also counts frames within a multiframe of 12 frames (superframe) or 24 frames (extended superframe), and it drives a sync pulse that can mark every frame or only the start of each multiframe. In frame mode the pulse can be stretched to two bits in signaling frames. The sync function can be switched to input: in that case the block drives no pulse, and an external pulse realigns the counters to a frame or multiframe boundary.

Top module: `t1_frame_timer`

## Requirements
- R1: A frame lasts 193 clock cycles. `fbit` is high for exactly the first cycle of each frame and is followed by channels 1 through 24.
- R2: Outside the framing bit, `chan_num` runs 1..24 and `bit_num` runs 1..8 within each channel, where bit 1 is the most significant bit and comes first. Both read 0 during the framing bit.
- R3: `chan_clk` is high only during bit 8 (the least significant bit) of each channel, so it pulses 24 times per frame.
- R4: `chan_gate` equals `chan_mask[n-1]` while channel n is carried (mask bit 0 belongs to channel 1, bit 23 to channel 24), and it is 0 during the framing bit.
- R5: `frame_num` counts 1..12 when `esf_mode` is 0 and 1..24 when `esf_mode` is 1. It advances on the framing bit of each new frame and wraps to 1 after the last frame.
- R6: With `sync_dir_in` = 0 and `sync_mf_sel` = 0, `sync_out` is high during the framing bit of every frame. With `sync_mf_sel` = 1 it is high only during the framing bit of frame 1.
- R7: With `sync_dir_in` = 0, `sync_mf_sel` = 0 and `sync_dbl_en` = 1, in signaling frames (`frame_num` a multiple of 6) `sync_out` also stays high for the bit after the framing bit (channel 1, bit 1). `sync_dbl_en` has no effect when `sync_mf_sel` = 1.
- R8: With `sync_dir_in` = 1, `sync_out` stays 0 whatever `sync_dbl_en` is. If `sync_in` is high at a clock edge, the next cycle is a framing bit, and `frame_num` becomes 1 when `sync_mf_sel` = 1 and is left unchanged when it is 0. With `sync_dir_in` = 0, `sync_in` has no effect.
- R9: After reset the outputs show the framing bit of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz bit clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| esf_mode | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| sync_mf_sel | input | 1 | 0: sync marks frames, 1: sync marks multiframes |
| sync_dbl_en | input | 1 | Stretch the frame sync to two bits in signaling frames |
| sync_dir_in | input | 1 | 1: sync is an input and `sync_out` is idle |
| sync_in | input | 1 | External boundary pulse, used when `sync_dir_in` = 1 |
| chan_mask | input | 24 | Per-channel gate mask, bit 0 = channel 1 |
| fbit | output | 1 | High during the framing bit |
| chan_num | output | 5 | Current channel 1..24, 0 during the framing bit |
| bit_num | output | 4 | Current bit 1..8 in the channel, 0 during the framing bit |
| chan_clk | output | 1 | High during bit 8 of each channel |
| chan_gate | output | 1 | Mask bit of the current channel |
| frame_num | output | 5 | Frame number within the multiframe, 1-based |
| sync_out | output | 1 | Frame or multiframe sync pulse |

## Verification
The hardest cases to reach are the sync behaviours that depend on a particular frame in the multiframe. These are the stretched pulse in frames 6, 12, 18 and 24, the wrap from frame 24 to 1 in extended mode, and a realigning pulse that comes in the middle of a frame and leaves the frame number either reset or held. The bench runs every mode combination for two full 24-frame multiframes and compares each output in every cycle against a bit-position reference model. It drives `sync_in` pulses at fixed offsets inside frames, in input mode and in output mode, so that both the realignment and the ignored case occur mid-frame.

// File: rtl/t1_ft_pkg.sv
// Package: shared constants for the T1 frame timing generator.
// Assumes the standard T1 layout: one framing bit followed by the channel payload.
package t1_ft_pkg;
    localparam int T1_CHANNELS  = 24;
    localparam int T1_CHAN_BITS = 8;
    localparam int T1_SF_FRAMES = 12;
    localparam int T1_EF_FRAMES = 24;
    localparam int T1_SIG_EVERY = 6;
endpackage

// File: rtl/t1_ft_pos_ctr.sv
// Module: bit-position counter inside a frame.
// Tracks the channel (0 = framing bit, 1..N_CHAN) and the bit within the channel (1..CHAN_BITS).
// Assumes one bit per clock. A reload forces the next cycle to be a framing bit.
module t1_ft_pos_ctr #(
    parameter int N_CHAN    = 24,
    parameter int CHAN_BITS = 8,
    localparam int CW = $clog2(N_CHAN + 1),
    localparam int BW = $clog2(CHAN_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    output logic [CW-1:0] chan_q,
    output logic [BW-1:0] bit_q,
    output logic          last_bit
);
    localparam logic [CW-1:0] LAST_CHAN = CW'(N_CHAN);
    localparam logic [BW-1:0] LAST_BIT  = BW'(CHAN_BITS);

    logic at_fbit;
    logic at_lsb;

    // Decode the points where the counters turn over.
    always_comb begin
        at_fbit  = (chan_q == '0);
        at_lsb   = (bit_q == LAST_BIT);
        last_bit = at_lsb && (chan_q == LAST_CHAN);
    end

    // Step through the framing bit, then each channel bit by bit.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            chan_q <= '0;
            bit_q  <= '0;
        end else if (at_fbit) begin
            chan_q <= CW'(1);
            bit_q  <= BW'(1);
        end else if (at_lsb) begin
            if (chan_q == LAST_CHAN) begin
                chan_q <= '0;
                bit_q  <= '0;
            end else begin
                chan_q <= chan_q + CW'(1);
                bit_q  <= BW'(1);
            end
        end else begin
            bit_q <= bit_q + BW'(1);
        end
    end
endmodule

// File: rtl/t1_ft_frame_ctr.sv
// Module: frame counter within a multiframe.
// Counts 1..SF_LEN or 1..EF_LEN and advances when the position counter passes its last bit.
// Assumes the multiframe length changes only while in reset. An out-of-range value wraps to 1.
module t1_ft_frame_ctr #(
    parameter int SF_LEN = 12,
    parameter int EF_LEN = 24,
    localparam int FW = $clog2(EF_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          esf_mode,
    input  logic          advance,
    input  logic          reload,
    input  logic          reload_first,
    output logic [FW-1:0] frame_q
);
    logic [FW-1:0] mf_last;

    // Select the multiframe length.
    always_comb mf_last = esf_mode ? FW'(EF_LEN) : FW'(SF_LEN);

    // Advance, wrap, or realign the frame number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= FW'(1);
        end else if (reload) begin
            if (reload_first) frame_q <= FW'(1);
        end else if (advance) begin
            frame_q <= (frame_q >= mf_last) ? FW'(1) : frame_q + FW'(1);
        end
    end
endmodule

// File: rtl/t1_ft_chan_gate.sv
// Module: per-channel gate and channel clock decode.
// The gate is the mask bit of the current channel (bit 0 = channel 1) and is 0 in the framing bit.
// The channel clock marks the last bit of every channel.
module t1_ft_chan_gate #(
    parameter int N_CHAN    = 24,
    parameter int CHAN_BITS = 8,
    localparam int CW = $clog2(N_CHAN + 1),
    localparam int BW = $clog2(CHAN_BITS + 1)
) (
    input  logic [CW-1:0]     chan_i,
    input  logic [BW-1:0]     bit_i,
    input  logic [N_CHAN-1:0] mask_i,
    output logic              gate_o,
    output logic              cclk_o
);
    logic [N_CHAN-1:0] hit;

    // One select term per channel, then OR them together.
    for (genvar c = 0; c < N_CHAN; c++) begin : g_sel
        always_comb hit[c] = (chan_i == CW'(c + 1)) && mask_i[c];
    end

    // Combine the channel selects and decode the channel clock.
    always_comb begin
        gate_o = |hit;
        cclk_o = (bit_i == BW'(CHAN_BITS));
    end
endmodule

// File: rtl/t1_ft_sync_gen.sv
// Module: frame / multiframe sync pulse generator.
// Frame mode: pulse in the framing bit, stretched by one bit in signaling frames when enabled.
// Multiframe mode: pulse only in the framing bit of frame 1. Idle when the sync is an input.
module t1_ft_sync_gen #(
    parameter int N_CHAN    = 24,
    parameter int CHAN_BITS = 8,
    parameter int EF_LEN    = 24,
    parameter int SIG_EVERY = 6,
    localparam int CW = $clog2(N_CHAN + 1),
    localparam int BW = $clog2(CHAN_BITS + 1),
    localparam int FW = $clog2(EF_LEN + 1)
) (
    input  logic [CW-1:0] chan_i,
    input  logic [BW-1:0] bit_i,
    input  logic [FW-1:0] frame_i,
    input  logic          mf_sel,
    input  logic          dbl_en,
    input  logic          dir_in,
    output logic          sync_o
);
    logic at_fbit;
    logic first_payload;
    logic sig_frame;

    // Classify the current bit and frame.
    always_comb begin
        at_fbit       = (chan_i == '0);
        first_payload = (chan_i == CW'(1)) && (bit_i == BW'(1));
        sig_frame     = ((frame_i % FW'(SIG_EVERY)) == '0);
    end

    // Form the pulse for the selected mode.
    always_comb begin
        if (dir_in)
            sync_o = 1'b0;
        else if (mf_sel)
            sync_o = at_fbit && (frame_i == FW'(1));
        else
            sync_o = at_fbit || (dbl_en && sig_frame && first_payload);
    end
endmodule

// File: rtl/t1_frame_timer.sv
// Module: T1 frame timing and channel gate generator (top).
// Assumes clk is the line bit clock with one bit per cycle and that the mode inputs are static
// outside reset. The outputs are decoded from the counter state, so they carry no added latency.
module t1_frame_timer #(
    parameter int N_CHAN    = t1_ft_pkg::T1_CHANNELS,
    parameter int CHAN_BITS = t1_ft_pkg::T1_CHAN_BITS,
    parameter int SF_LEN    = t1_ft_pkg::T1_SF_FRAMES,
    parameter int EF_LEN    = t1_ft_pkg::T1_EF_FRAMES,
    parameter int SIG_EVERY = t1_ft_pkg::T1_SIG_EVERY,
    localparam int CW = $clog2(N_CHAN + 1),
    localparam int BW = $clog2(CHAN_BITS + 1),
    localparam int FW = $clog2(EF_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esf_mode,
    input  logic              sync_mf_sel,
    input  logic              sync_dbl_en,
    input  logic              sync_dir_in,
    input  logic              sync_in,
    input  logic [N_CHAN-1:0] chan_mask,
    output logic              fbit,
    output logic [CW-1:0]     chan_num,
    output logic [BW-1:0]     bit_num,
    output logic              chan_clk,
    output logic              chan_gate,
    output logic [FW-1:0]     frame_num,
    output logic              sync_out
);
    logic reload;
    logic last_bit;

    // Accept an external boundary only when the sync is an input.
    always_comb reload = sync_dir_in && sync_in;

    t1_ft_pos_ctr #(.N_CHAN(N_CHAN), .CHAN_BITS(CHAN_BITS)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .chan_q   (chan_num),
        .bit_q    (bit_num),
        .last_bit (last_bit)
    );

    t1_ft_frame_ctr #(.SF_LEN(SF_LEN), .EF_LEN(EF_LEN)) u_frm (
        .clk          (clk),
        .rst_n        (rst_n),
        .esf_mode     (esf_mode),
        .advance      (last_bit),
        .reload       (reload),
        .reload_first (sync_mf_sel),
        .frame_q      (frame_num)
    );

    t1_ft_chan_gate #(.N_CHAN(N_CHAN), .CHAN_BITS(CHAN_BITS)) u_gate (
        .chan_i (chan_num),
        .bit_i  (bit_num),
        .mask_i (chan_mask),
        .gate_o (chan_gate),
        .cclk_o (chan_clk)
    );

    t1_ft_sync_gen #(.N_CHAN(N_CHAN), .CHAN_BITS(CHAN_BITS), .EF_LEN(EF_LEN),
                     .SIG_EVERY(SIG_EVERY)) u_sync (
        .chan_i  (chan_num),
        .bit_i   (bit_num),
        .frame_i (frame_num),
        .mf_sel  (sync_mf_sel),
        .dbl_en  (sync_dbl_en),
        .dir_in  (sync_dir_in),
        .sync_o  (sync_out)
    );

    // Flag the framing-bit time.
    always_comb fbit = (chan_num == '0);
endmodule

// File: rtl/t1_frame_timer_chk.sv
// Module: assertion checker for t1_frame_timer, attached by the bind below.
module t1_frame_timer_chk #(
    parameter int N_CHAN    = 24,
    parameter int CHAN_BITS = 8,
    parameter int SF_LEN    = 12,
    parameter int EF_LEN    = 24,
    localparam int CW = $clog2(N_CHAN + 1),
    localparam int BW = $clog2(CHAN_BITS + 1),
    localparam int FW = $clog2(EF_LEN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          esf_mode,
    input logic          sync_mf_sel,
    input logic          sync_dir_in,
    input logic          sync_in,
    input logic          fbit,
    input logic [CW-1:0] chan_num,
    input logic [BW-1:0] bit_num,
    input logic          chan_clk,
    input logic          chan_gate,
    input logic [FW-1:0] frame_num,
    input logic          sync_out
);
    AST_FBIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_num == CW'(N_CHAN) && bit_num == BW'(CHAN_BITS)) |=> fbit); // R1

    AST_CCLK_THEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk |=> (fbit || bit_num == BW'(1))); // R3

    AST_GATE_LOW_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
        fbit |-> !chan_gate); // R4

    AST_FRAME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num >= FW'(1)) && (frame_num <= (esf_mode ? FW'(EF_LEN) : FW'(SF_LEN)))); // R5

    AST_MF_PULSE_FRAME1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_dir_in && sync_mf_sel && sync_out) |-> (fbit && frame_num == FW'(1))); // R6

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_dir_in |-> !sync_out); // R8

    AST_INPUT_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_dir_in && sync_in) |=> fbit); // R8
endmodule

bind t1_frame_timer t1_frame_timer_chk #(
    .N_CHAN(N_CHAN), .CHAN_BITS(CHAN_BITS), .SF_LEN(SF_LEN), .EF_LEN(EF_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .esf_mode    (esf_mode),
    .sync_mf_sel (sync_mf_sel),
    .sync_dir_in (sync_dir_in),
    .sync_in     (sync_in),
    .fbit        (fbit),
    .chan_num    (chan_num),
    .bit_num     (bit_num),
    .chan_clk    (chan_clk),
    .chan_gate   (chan_gate),
    .frame_num   (frame_num),
    .sync_out    (sync_out)
);

// File: tb/t1_frame_timer_bench.sv
module t1_frame_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        esf_mode = 1'b0;
    logic        sync_mf_sel = 1'b0;
    logic        sync_dbl_en = 1'b0;
    logic        sync_dir_in = 1'b0;
    logic        sync_in = 1'b0;
    logic [23:0] chan_mask = '0;
    logic        fbit;
    logic [4:0]  chan_num;
    logic [3:0]  bit_num;
    logic        chan_clk;
    logic        chan_gate;
    logic [4:0]  frame_num;
    logic        sync_out;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;
    int frm    = 1;

    always #4 clk = ~clk;

    t1_frame_timer u_t1_frame_timer (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .sync_mf_sel(sync_mf_sel),
        .sync_dbl_en(sync_dbl_en), .sync_dir_in(sync_dir_in), .sync_in(sync_in),
        .chan_mask(chan_mask), .fbit(fbit), .chan_num(chan_num), .bit_num(bit_num),
        .chan_clk(chan_clk), .chan_gate(chan_gate), .frame_num(frame_num), .sync_out(sync_out)
    );

    // {dir_in, esf, mf_sel, dbl_en, mask}
    localparam int NVEC = 6;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'b0001, 24'hA53C81},
        {4'b0101, 24'h800001},
        {4'b0111, 24'hFFFFFF},
        {4'b0010, 24'h000000},
        {4'b1111, 24'h5A5A5A},
        {4'b1001, 24'h0F0F0F}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 40)
                $display("FAIL %s pos=%0d frame=%0d actual=%0d expected=%0d",
                         req, pos, frm, act, exp);
        end
    endtask

    // Reference model: compare all outputs for the current bit position.
    task automatic compare_all();
        int ec, eb, es, sig;
        ec  = (pos == 0) ? 0 : (pos - 1) / 8 + 1;
        eb  = (pos == 0) ? 0 : (pos - 1) % 8 + 1;
        sig = (frm % 6 == 0);
        if (sync_dir_in)      es = 0;
        else if (sync_mf_sel) es = (pos == 0 && frm == 1);
        else                  es = (pos == 0) || (sync_dbl_en && sig && pos == 1);
        chk("R1 fbit",  int'(fbit), int'(pos == 0));
        chk("R2 chan",  int'(chan_num), ec);
        chk("R2 bit",   int'(bit_num), eb);
        chk("R3 cclk",  int'(chan_clk), int'(eb == 8));
        chk("R4 gate",  int'(chan_gate), (ec == 0) ? 0 : int'(chan_mask[ec - 1]));
        chk("R5 frame", int'(frame_num), frm);
        chk("R6/R7/R8 sync", int'(sync_out), es);
    endtask

    // Advance the reference model across one clock edge.
    task automatic model_step(input logic rin);
        if (sync_dir_in && rin) begin
            pos = 0;
            if (sync_mf_sel) frm = 1;
        end else if (pos == 192) begin
            pos = 0;
            frm = (frm >= (esf_mode ? 24 : 12)) ? 1 : frm + 1;
        end else begin
            pos = pos + 1;
        end
    endtask

    // One bit time: check at the falling edge, drive sync_in, cross the rising edge.
    task automatic bit_cycle(input logic rin);
        compare_all();
        sync_in = rin;
        @(posedge clk);
        model_step(rin);
        @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pos = 0;
        frm = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // Vector loop: each mode combination for two full 24-frame spans.
        for (int v = 0; v < NVEC; v++) begin
            {sync_dir_in, esf_mode, sync_mf_sel, sync_dbl_en, chan_mask} = VEC[v];
            apply_reset();
            for (int i = 0; i < 9264; i++)
                bit_cycle((i % 1500) == 700 || (i % 2311) == 1999);
        end

        // Directed R9: reset state in multiframe output mode.
        {sync_dir_in, esf_mode, sync_mf_sel, sync_dbl_en, chan_mask} = {4'b0110, 24'hFFFFFF};
        apply_reset();
        chk("R9 fbit",  int'(fbit), 1);
        chk("R9 chan",  int'(chan_num), 0);
        chk("R9 frame", int'(frame_num), 1);
        chk("R9 sync",  int'(sync_out), 1);
        chk("R9 gate",  int'(chan_gate), 0);

        // Directed R8: a realign pulse at the last bit of frame 3 in frame mode keeps frame 3.
        {sync_dir_in, esf_mode, sync_mf_sel, sync_dbl_en, chan_mask} = {4'b1100, 24'h000001};
        apply_reset();
        for (int i = 0; i < 2 * 193 + 192; i++) bit_cycle(1'b0);
        bit_cycle(1'b1);
        chk("R8 hold frame", int'(frame_num), 3);
        chk("R8 fbit",       int'(fbit), 1);
        bit_cycle(1'b0);
        chk("R4 ch1 gate",   int'(chan_gate), 1);

        // Directed R7: the stretch is ignored in multiframe mode during frame 6.
        {sync_dir_in, esf_mode, sync_mf_sel, sync_dbl_en, chan_mask} = {4'b0011, 24'h000000};
        apply_reset();
        for (int i = 0; i < 5 * 193 + 1; i++) bit_cycle(1'b0);
        chk("R7 ignored in mf", int'(sync_out), 0);
        chk("R7 frame6",        int'(frame_num), 6);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule